// File: doc/BRIEF.md
# Network Controller Interrupt Register Unit

This unit gathers eight interrupt causes of a network controller into one 8-bit status byte. It drives a single active-high interrupt line from the causes the host has enabled. The status byte and an enable byte share one 16-bit word of the register space. The low byte, at byte offset C, reads as status and takes writes as acknowledge. The high byte, at byte offset D, is the enable (mask) byte and reads back what was written. A host may access the word as a whole or either byte alone, selected by two byte-lane enables.

Four of the causes are events: a one-cycle pulse from the datapath latches them, and they stay set until the host acknowledges them. The other four are live conditions. They are shown exactly as the datapath presents them and cannot be acknowledged. One of the live conditions is the transmit-idle flag, which is high whenever the transmit sequencer is not running. This holds even if frames are still queued for transmission. The host therefore uses it to know when the current frame has finished, for example before putting a new frame at the head of the queue.

Top module: `irq_unit`

## Requirements
- R1: A read with `bus_addr[3:1]` = 3'b110 (byte offsets C and D) returns the status byte in `bus_rdata[7:0]` and the mask byte in `bus_rdata[15:8]`. Any other address reads as 16'h0000.
- R2: The status bits 1 (transmit done), 2 (transmit queue empty), 4 (receive overrun) and 6 (early receive) are latched. A one-cycle pulse on the matching `evt_*` input sets the bit from the next clock edge, and the bit stays set until it is acknowledged.
- R3: The status bits 0 (receive pending), 3 (allocation ready) and 5 (PHY/MAC condition) follow their `lvl_*` inputs in the same cycle. Bit 7 (transmit idle) equals the inverse of `tx_active` and depends on nothing else.
- R4: A write with `bus_be[0]` = 1 to the word clears, at the next edge, every latched status bit whose position holds a 1 in `bus_wdata[7:0]`. A 0 in a position leaves that bit unchanged.
- R5: Acknowledge writes to bit positions 0, 3, 5 and 7 have no effect. Those bits keep following their live inputs.
- R6: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit is set after the edge.
- R7: Reset (`rst_n` = 0) clears the mask byte and every latched status bit.
- R8: A write with `bus_be[1]` = 1 loads `bus_wdata[15:8]` into the mask byte. With `bus_be[1]` = 0 the mask is unchanged, so a byte write touches only its own lane and a word write updates both lanes.
- R9: `irq` is the OR over all eight positions of status AND mask. It changes in the same cycle as status or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address within the register bank |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_be | input | 2 | Byte-lane enables: bit 0 for offset C, bit 1 for offset D |
| bus_wdata | input | 16 | Write data: low byte is acknowledge, high byte is mask |
| bus_rdata | output | 16 | Read data: low byte is status, high byte is mask |
| evt_tx_done | input | 1 | Pulse: a frame finished transmitting |
| evt_tx_empty | input | 1 | Pulse: the transmit queue ran empty |
| evt_rx_ovrun | input | 1 | Pulse: a received frame was dropped |
| evt_early_rx | input | 1 | Pulse: the early-receive threshold was reached |
| lvl_rx_pend | input | 1 | Level: received frames are waiting |
| lvl_alloc_ok | input | 1 | Level: a buffer allocation is ready |
| lvl_phy_evt | input | 1 | Level: a PHY/MAC condition is present |
| tx_active | input | 1 | Level: the transmit sequencer is running |
| irq | output | 1 | Hardware interrupt request |

## Verification
The bench first applies directed patterns, and each one separates one rule from its neighbours. Lone event pulses with no acknowledge show that the bits latch. An acknowledge of all ones aimed at live positions must change nothing. A pulse and an acknowledge of the same bit in the same cycle expose the wrong priority. Byte-only writes to each lane catch a lane that leaks into the other. Toggling `tx_active` with the other inputs held shows that transmit idle depends only on the sequencer. A long run with random event, level, address and lane patterns then compares read data and the interrupt line against a behavioural model every cycle. This catches wrong interactions between masking, acknowledging and live inputs.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
    localparam int IRQ_W = 8;

    localparam int BIT_RX_PEND  = 0;
    localparam int BIT_TX_DONE  = 1;
    localparam int BIT_TX_EMPTY = 2;
    localparam int BIT_ALLOC    = 3;
    localparam int BIT_OVRUN    = 4;
    localparam int BIT_PHY      = 5;
    localparam int BIT_EARLY    = 6;
    localparam int BIT_TX_IDLE  = 7;

    // positions that latch an event and accept acknowledge
    localparam logic [IRQ_W-1:0] LATCHED_BITS =
        (IRQ_W'(1) << BIT_TX_DONE) | (IRQ_W'(1) << BIT_TX_EMPTY) |
        (IRQ_W'(1) << BIT_OVRUN)   | (IRQ_W'(1) << BIT_EARLY);
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int                    W        = 8,
    parameter logic [W-1:0]          CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } latch_st_t;

    latch_st_t    st_d, st_q;
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (CLR_MASK[i]) begin : g_latched
            // a new event outranks a same-cycle clear
            assign nxt[i] = set_i[i] | (st_q.flags[i] & ~clr_i[i]);
        end else begin : g_live
            assign nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port #(
    parameter int          W        = 8,
    parameter int          ADDR_W   = 4,
    parameter int unsigned WORD_OFS = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [1:0]        be_i,
    input  logic [2*W-1:0]    wdata_i,
    input  logic [W-1:0]      status_i,
    input  logic [W-1:0]      mask_i,
    output logic [W-1:0]      ack_o,
    output logic              mask_we_o,
    output logic [W-1:0]      mask_wdata_o,
    output logic [2*W-1:0]    rdata_o
);
    localparam logic [ADDR_W-2:0] WORD_IDX = WORD_OFS[ADDR_W-1:1];

    logic hit;

    always_comb begin
        hit          = (addr_i[ADDR_W-1:1] == WORD_IDX);
        ack_o        = (hit && wr_i && be_i[0]) ? wdata_i[W-1:0] : '0;
        mask_we_o    = hit && wr_i && be_i[1];
        mask_wdata_o = wdata_i[2*W-1:W];
        rdata_o      = hit ? {mask_i, status_i} : '0;
    end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
    parameter int          ADDR_W   = 4,
    parameter int unsigned WORD_OFS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        evt_tx_done,
    input  logic        evt_tx_empty,
    input  logic        evt_rx_ovrun,
    input  logic        evt_early_rx,
    input  logic        lvl_rx_pend,
    input  logic        lvl_alloc_ok,
    input  logic        lvl_phy_evt,
    input  logic        tx_active,
    output logic        irq
);
    import irq_unit_pkg::*;

    logic [IRQ_W-1:0] set_w, live_w, latched_w, status_w, mask_q, ack_w, mask_wd;
    logic             mask_we;

    always_comb begin
        set_w               = '0;
        set_w[BIT_TX_DONE]  = evt_tx_done;
        set_w[BIT_TX_EMPTY] = evt_tx_empty;
        set_w[BIT_OVRUN]    = evt_rx_ovrun;
        set_w[BIT_EARLY]    = evt_early_rx;

        live_w              = '0;
        live_w[BIT_RX_PEND] = lvl_rx_pend;
        live_w[BIT_ALLOC]   = lvl_alloc_ok;
        live_w[BIT_PHY]     = lvl_phy_evt;
        live_w[BIT_TX_IDLE] = ~tx_active;
    end

    irq_latch_bank #(.W(IRQ_W), .CLR_MASK(LATCHED_BITS)) u_latch (
        .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(ack_w), .flags_o(latched_w)
    );

    irq_mask_reg #(.W(IRQ_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .we_i(mask_we), .wdata_i(mask_wd), .mask_o(mask_q)
    );

    irq_bus_port #(.W(IRQ_W), .ADDR_W(ADDR_W), .WORD_OFS(WORD_OFS)) u_bus (
        .addr_i(bus_addr), .wr_i(bus_wr), .be_i(bus_be), .wdata_i(bus_wdata),
        .status_i(status_w), .mask_i(mask_q), .ack_o(ack_w),
        .mask_we_o(mask_we), .mask_wdata_o(mask_wd), .rdata_o(bus_rdata)
    );

    assign status_w = (latched_w & LATCHED_BITS) | (live_w & ~LATCHED_BITS);
    assign irq      = |(status_w & mask_q);
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_wr,
    input logic [1:0]  bus_be,
    input logic [15:0] bus_wdata,
    input logic        evt_rx_ovrun,
    input logic        evt_early_rx,
    input logic        tx_active,
    input logic [7:0]  status_w,
    input logic [7:0]  mask_q,
    input logic        irq
);
    logic hit;
    assign hit = (bus_addr[3:1] == 3'b110);

    AST_MASK_RESET: assert property (@(posedge clk) !rst_n |=> (mask_q == 8'h00)); // R7
    AST_TXIDLE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> status_w[7]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_ovrun |=> status_w[4]); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && bus_be[0] && bus_wdata[6] && !evt_early_rx) |=> !status_w[6]); // R4
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |-> !irq); // R9
    AST_MASK_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_wr && bus_be[1]) |=> $stable(mask_q)); // R8
endmodule

bind irq_unit irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .evt_rx_ovrun(evt_rx_ovrun),
    .evt_early_rx(evt_early_rx), .tx_active(tx_active),
    .status_w(status_w), .mask_q(mask_q), .irq(irq)
);

// File: tb/sim_irq_unit.sv
`timescale 1ns/1ps
module sim_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'hC;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        evt_tx_done = 0, evt_tx_empty = 0, evt_rx_ovrun = 0, evt_early_rx = 0;
    logic        lvl_rx_pend = 0, lvl_alloc_ok = 0, lvl_phy_evt = 0, tx_active = 1;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [7:0] m_lat  = 8'h00;
    logic [7:0] m_mask = 8'h00;

    always #10 clk = ~clk;

    irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_tx_done(evt_tx_done), .evt_tx_empty(evt_tx_empty),
        .evt_rx_ovrun(evt_rx_ovrun), .evt_early_rx(evt_early_rx),
        .lvl_rx_pend(lvl_rx_pend), .lvl_alloc_ok(lvl_alloc_ok),
        .lvl_phy_evt(lvl_phy_evt), .tx_active(tx_active), .irq(irq)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s    = m_lat;
        s[0] = lvl_rx_pend;
        s[3] = lvl_alloc_ok;
        s[5] = lvl_phy_evt;
        s[7] = ~tx_active;
        return s;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare the settled outputs, then step one clock and advance the model
    task automatic cyc(input string tag);
        logic [15:0] er;
        logic [7:0]  ev;
        #1;
        er = (bus_addr[3:1] == 3'b110) ? {m_mask, exp_status()} : 16'h0000;
        check({tag, " rdata"}, bus_rdata, er);
        check("R9 irq", {15'h0, irq}, {15'h0, |(exp_status() & m_mask)});
        @(posedge clk);
        if (!rst_n) begin
            m_lat  = 8'h00;
            m_mask = 8'h00;
        end else begin
            ev = {1'b0, evt_early_rx, 1'b0, evt_rx_ovrun, 1'b0, evt_tx_empty, evt_tx_done, 1'b0};
            if (bus_addr[3:1] == 3'b110 && bus_wr && bus_be[0])
                m_lat = m_lat & ~(bus_wdata[7:0] & 8'b0101_0110);
            m_lat = m_lat | ev;
            if (bus_addr[3:1] == 3'b110 && bus_wr && bus_be[1])
                m_mask = bus_wdata[15:8];
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        bus_wr = 0; bus_be = 2'b00; bus_addr = 4'hC;
        evt_tx_done = 0; evt_tx_empty = 0; evt_rx_ovrun = 0; evt_early_rx = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
        bus_addr = a; bus_wr = 1; bus_be = be; bus_wdata = d;
    endtask

    initial begin : watchdog
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R7: reset state, while the design is held
        lvl_rx_pend = 1;
        cyc("R7 reset");
        cyc("R7 reset");
        rst_n = 1;
        cyc("R7 after reset");
        lvl_rx_pend = 0;

        // R8: mask written through lane 1 only
        wr(4'hD, 2'b10, 16'hA5FF); cyc("R8 mask lane");
        idle_in(); cyc("R8 mask readback");
        wr(4'hC, 2'b01, 16'h3C00); cyc("R8 ack lane keeps mask");
        idle_in(); cyc("R8 mask unchanged");
        wr(4'hC, 2'b11, 16'hFF00); cyc("R8 word write");
        idle_in(); cyc("R8 word readback");

        // R2: lone event pulses latch
        evt_tx_done = 1; evt_rx_ovrun = 1; cyc("R2 pulse");
        idle_in(); cyc("R2 held"); cyc("R2 held");
        evt_tx_empty = 1; evt_early_rx = 1; cyc("R2 pulse");
        idle_in(); cyc("R2 all latched");

        // R4: acknowledge clears only ones
        wr(4'hC, 2'b01, 16'h0012); cyc("R4 ack partial");
        idle_in(); cyc("R4 after ack");
        wr(4'hC, 2'b01, 16'h0044); cyc("R4 ack rest");
        idle_in(); cyc("R4 clear");

        // R5: acknowledge of live positions has no effect
        lvl_rx_pend = 1; lvl_alloc_ok = 1; lvl_phy_evt = 1; tx_active = 0;
        wr(4'hC, 2'b01, 16'h00A9); cyc("R5 ack live");
        idle_in(); cyc("R5 live held");

        // R3: live bits follow their inputs; transmit idle only on tx_active
        tx_active = 1; cyc("R3 tx busy");
        tx_active = 0; cyc("R3 tx idle");
        lvl_rx_pend = 0; lvl_alloc_ok = 0; lvl_phy_evt = 0; cyc("R3 levels low");

        // R6: set wins over same-cycle acknowledge
        evt_rx_ovrun = 1; evt_early_rx = 1;
        wr(4'hC, 2'b01, 16'h0050); cyc("R6 set vs ack");
        idle_in(); cyc("R6 set kept");

        // R1: other addresses read zero
        bus_addr = 4'h8; cyc("R1 other addr");
        bus_addr = 4'hE; cyc("R1 other addr");
        bus_addr = 4'hD; cyc("R1 odd offset");

        // R9: mask gates interrupt
        wr(4'hD, 2'b10, 16'h0000); cyc("R9 mask off");
        idle_in(); cyc("R9 no irq");
        wr(4'hD, 2'b10, 16'h1000); cyc("R9 ovrun only");
        idle_in(); cyc("R9 irq on");

        // random patterns compared every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            evt_tx_done  = (r[2:0] == 0);
            evt_tx_empty = (r[5:3] == 0);
            evt_rx_ovrun = (r[8:6] == 0);
            evt_early_rx = (r[11:9] == 0);
            lvl_rx_pend  = r[12];
            lvl_alloc_ok = r[13];
            lvl_phy_evt  = r[14];
            tx_active    = r[15];
            bus_wr       = r[16];
            bus_be       = r[18:17];
            bus_addr     = r[19] ? {3'b110, r[20]} : r[23:20];
            bus_wdata    = $urandom;
            cyc("R1 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule